// File: doc/BRIEF.md
# System Control Register Block

This block holds the core system-control registers of a microcontroller interrupt controller and presents them on a simple word-addressed register port. Most read values are built at the moment of the read from live exception state supplied by the interrupt core: the running exception number, the highest pending vector, and per-exception pending and active flags. Writes turn into one-cycle request pulses toward the core (set or clear pending for the two software-pendable system exceptions), or update stored configuration: the vector table base, the priority-grouping field, three fault-handler enables, twelve system-handler priority bytes and the tick-timer control bits.

The tick timer itself, reset generation and fault status live elsewhere. The timer reports each wrap through `tick_wrap`. The block keeps the sticky count flag that a control/status read returns and clears. A grouping write raises `prio_recalc` for one cycle so that the priority logic re-derives effective priorities for exceptions 4 and up.

Register offsets below are byte offsets. `bus_addr` carries offset bits 11:2. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd` and holds until the next read.

Top module: `sysctl_regs`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: `bus_rdata`, `vtor`, `prigroup`, `hnd_en`, `sys_prio`, `tick_ctrl`, the count flag and every request pulse.
- R2: A read of 0xD04 returns `act_exc` in bits VEC_W-1:0, `pend_vec` from bit 12 upward, `ext_pend_any` at bit 22, and the pending flags of exception 15 at bit 26, exception 14 at bit 28 and exception 2 at bit 31, all sampled at the read edge; the other bits read 0.
- R3: On a write to 0xD04 with bit 28 set, `pendsv_set` pulses high for the following cycle. With bit 28 clear and bit 27 set, `pendsv_clr` pulses instead. The two never pulse together.
- R4: On a write to 0xD04, bit 26 and bit 25 drive `systick_set` and `systick_clr` under the same rule, with the set bit winning.
- R5: A write to 0xD08 stores the data with bits 6:0 forced to 0. The stored value drives `vtor` and is what a read returns.
- R6: A read of 0xD0C returns 0xFA05 in bits 31:16 and the grouping field in bits 10:8, with the other bits 0. A write stores data bits 10:8 as `prigroup` and pulses `prio_recalc` for one cycle.
- R7: A read of 0xD24 returns active flags in these bits: bit 0 for exception 4, bit 1 for 5, bit 3 for 6, bit 7 for 11, bit 8 for 12, bit 10 for 14, bit 11 for 15. It returns pending flags in these bits: bit 12 for 6, bit 13 for 4, bit 14 for 5, bit 15 for 11. Bits 18:16 return the enables of exceptions 6, 5 and 4. A write updates only those three enables (`hnd_en[0]`=exception 4, `[1]`=5, `[2]`=6).
- R8: Words 0xD18, 0xD1C and 0xD20 hold priority bytes for exceptions 4..15, lowest byte lane first. A write updates only the lanes whose `bus_be` bit is set. Byte k of `sys_prio` is exception k+4.
- R9: 0x010 holds writable control bits 2:0 (`tick_ctrl`) and returns the count flag at bit 16. `tick_wrap` sets the flag. A read returns the flag and then clears it, unless a wrap arrives in the same cycle, in which case the flag stays set.
- R10: A read of 0x01C returns the calibration constant CALIB_VAL (default 10000).
- R11: A read of any other offset returns 0, and a write to it changes no output or stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte offset bits 11:2 |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lanes for priority writes |
| bus_rdata | output | 32 | Registered read data |
| act_exc | input | VEC_W | Running exception number |
| pend_vec | input | VEC_W | Highest pending vector |
| ext_pend_any | input | 1 | Any external interrupt pending |
| exc_pend | input | 16 | Pending flags of exceptions 0..15 |
| exc_act | input | 16 | Active flags of exceptions 0..15 |
| tick_wrap | input | 1 | Tick timer wrapped this cycle |
| pendsv_set | output | 1 | Request: set exception 14 pending |
| pendsv_clr | output | 1 | Request: clear exception 14 pending |
| systick_set | output | 1 | Request: set exception 15 pending |
| systick_clr | output | 1 | Request: clear exception 15 pending |
| hnd_en | output | 3 | Fault handler enables (4, 5, 6) |
| prigroup | output | 3 | Priority grouping field |
| prio_recalc | output | 1 | One-cycle priority recompute request |
| vtor | output | 32 | Vector table base |
| sys_prio | output | 96 | Priority bytes of exceptions 4..15 |
| tick_ctrl | output | 3 | Tick timer control bits |

## Verification
Two pairs of functions can land in the same cycle. The first is a timer wrap arriving on the very edge that a control/status read clears the count flag. The second is a control/state write that carries both the set bit and the clear bit of one exception. The bench drives a wrap and a read together, then reads twice more: the flag must show 1 once and then 0. It also writes every combination of bits 28/27 and 26/25 and expects only the set pulse whenever both bits are present. A reference model in the bench predicts every output on every clock, and a random phase repeats these collisions with live exception inputs that change on each cycle.

// File: rtl/sysctl_pkg.sv
// Package: shared register-select type, word offsets and exception numbers
// for the system control register block. Offsets are byte offsets >> 2.
package sysctl_pkg;

    localparam int AW = 10;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TCSR,
        SEL_TCAL,
        SEL_ICSR,
        SEL_VTOR,
        SEL_AIRCR,
        SEL_SHP0,
        SEL_SHP1,
        SEL_SHP2,
        SEL_SHCSR
    } sel_e;

    localparam logic [AW-1:0] W_TCSR  = 10'h004;  // 0x010
    localparam logic [AW-1:0] W_TCAL  = 10'h007;  // 0x01C
    localparam logic [AW-1:0] W_ICSR  = 10'h341;  // 0xD04
    localparam logic [AW-1:0] W_VTOR  = 10'h342;  // 0xD08
    localparam logic [AW-1:0] W_AIRCR = 10'h343;  // 0xD0C
    localparam logic [AW-1:0] W_SHP0  = 10'h346;  // 0xD18
    localparam logic [AW-1:0] W_SHP1  = 10'h347;  // 0xD1C
    localparam logic [AW-1:0] W_SHP2  = 10'h348;  // 0xD20
    localparam logic [AW-1:0] W_SHCSR = 10'h349;  // 0xD24

    localparam int EX_NMI    = 2;
    localparam int EX_MEM    = 4;
    localparam int EX_BUS    = 5;
    localparam int EX_USAGE  = 6;
    localparam int EX_SVC    = 11;
    localparam int EX_DBG    = 12;
    localparam int EX_PENDSV = 14;
    localparam int EX_TICK   = 15;

    localparam logic [15:0] RESET_KEY = 16'hFA05;

endpackage

// File: rtl/sysctl_decode.sv
// Module: sysctl_decode
// Maps a word address onto a register select. It is purely combinational.
// Assumes the address already has the byte-lane bits removed.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [AW-1:0] addr,
    output sel_e          sel
);

    // Compare the word address against every implemented register.
    always_comb begin
        unique case (addr)
            W_TCSR:  sel = SEL_TCSR;
            W_TCAL:  sel = SEL_TCAL;
            W_ICSR:  sel = SEL_ICSR;
            W_VTOR:  sel = SEL_VTOR;
            W_AIRCR: sel = SEL_AIRCR;
            W_SHP0:  sel = SEL_SHP0;
            W_SHP1:  sel = SEL_SHP1;
            W_SHP2:  sel = SEL_SHP2;
            W_SHCSR: sel = SEL_SHCSR;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysctl_prio.sv
// Module: sysctl_prio
// Holds NWORDS*4 byte-wide handler priorities. Each word write updates only
// the lanes that are enabled. Byte k of the flat output belongs to
// exception k+4. Assumes at most one word select is high per cycle.
module sysctl_prio #(
    parameter int NWORDS = 3,
    parameter int PW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NWORDS-1:0]       wr_word,
    input  logic [3:0]              be,
    input  logic [4*PW-1:0]         wdata,
    output logic [NWORDS*4*PW-1:0]  prio
);

    localparam int NBYTES = NWORDS * 4;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam int WI = k / 4;
        localparam int LN = k % 4;
        logic [PW-1:0] val;

        // Load one priority byte when its word and lane are both selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val <= '0;
            end else if (wr_word[WI] && be[LN]) begin
                val <= wdata[LN*PW +: PW];
            end
        end

        assign prio[k*PW +: PW] = val;
    end

endmodule

// File: rtl/sysctl_tick.sv
// Module: sysctl_tick
// Holds the tick-timer control bits and the sticky count flag. A wrap sets
// the flag, and a control/status read clears it; when both happen in one
// cycle the wrap wins. Counting is done outside this block.
module sysctl_tick #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    input  logic          rd_en,
    input  logic          wrap,
    output logic [CW-1:0] ctrl,
    output logic          flag
);

    // Store the writable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= wdata;
        end
    end

    // Sticky count flag: set by a wrap, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (rd_en) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
// Module: sysctl_regs (top)
// System control register group of an interrupt controller. Reads are built
// from stored configuration and from live exception state sampled at the
// read edge. Writes produce one-cycle request pulses or update stored
// fields. Assumes VEC_W <= 10, so the pending vector field ends below bit 22.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int          VEC_W     = 9,
    parameter logic [31:0] CALIB_VAL = 32'd10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [9:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_be,
    output logic [31:0]        bus_rdata,
    input  logic [VEC_W-1:0]   act_exc,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic               ext_pend_any,
    input  logic [15:0]        exc_pend,
    input  logic [15:0]        exc_act,
    input  logic               tick_wrap,
    output logic               pendsv_set,
    output logic               pendsv_clr,
    output logic               systick_set,
    output logic               systick_clr,
    output logic [2:0]         hnd_en,
    output logic [2:0]         prigroup,
    output logic               prio_recalc,
    output logic [31:0]        vtor,
    output logic [95:0]        sys_prio,
    output logic [2:0]         tick_ctrl
);

    localparam int NSHP      = 3;
    localparam int PEND_LSB  = 12;
    localparam int VT_ALIGN  = 7;

    sel_e               sel;
    logic               wr_icsr;
    logic               wr_aircr;
    logic               wr_vtor;
    logic               wr_shcsr;
    logic               wr_tcsr;
    logic               rd_tcsr;
    logic [NSHP-1:0]    wr_shp;
    logic               tick_flag;
    logic [31:0]        rd_val;
    logic               unused_ok;

    sysctl_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Strobes for each register that has a write or a read side effect.
    always_comb begin
        wr_icsr  = bus_wr && (sel == SEL_ICSR);
        wr_aircr = bus_wr && (sel == SEL_AIRCR);
        wr_vtor  = bus_wr && (sel == SEL_VTOR);
        wr_shcsr = bus_wr && (sel == SEL_SHCSR);
        wr_tcsr  = bus_wr && (sel == SEL_TCSR);
        rd_tcsr  = bus_rd && (sel == SEL_TCSR);
        wr_shp   = {bus_wr && (sel == SEL_SHP2),
                    bus_wr && (sel == SEL_SHP1),
                    bus_wr && (sel == SEL_SHP0)};
    end

    sysctl_prio #(
        .NWORDS (NSHP),
        .PW     (8)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_word (wr_shp),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .prio    (sys_prio)
    );

    sysctl_tick #(
        .CW (3)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_tcsr),
        .wdata (bus_wdata[2:0]),
        .rd_en (rd_tcsr),
        .wrap  (tick_wrap),
        .ctrl  (tick_ctrl),
        .flag  (tick_flag)
    );

    // Pending requests from a control/state write; the set bit beats the clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pendsv_set  <= 1'b0;
            pendsv_clr  <= 1'b0;
            systick_set <= 1'b0;
            systick_clr <= 1'b0;
        end else begin
            pendsv_set  <= wr_icsr && bus_wdata[28];
            pendsv_clr  <= wr_icsr && !bus_wdata[28] && bus_wdata[27];
            systick_set <= wr_icsr && bus_wdata[26];
            systick_clr <= wr_icsr && !bus_wdata[26] && bus_wdata[25];
        end
    end

    // Priority grouping field and its one-cycle recompute request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prigroup    <= '0;
            prio_recalc <= 1'b0;
        end else begin
            prio_recalc <= wr_aircr;
            if (wr_aircr) begin
                prigroup <= bus_wdata[10:8];
            end
        end
    end

    // Vector table base, stored with the alignment bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtor <= '0;
        end else if (wr_vtor) begin
            vtor <= {bus_wdata[31:VT_ALIGN], {VT_ALIGN{1'b0}}};
        end
    end

    // Fault handler enables: bit 0 = exc 4, bit 1 = exc 5, bit 2 = exc 6.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hnd_en <= '0;
        end else if (wr_shcsr) begin
            hnd_en <= bus_wdata[18:16];
        end
    end

    // Build the read value of the selected register from state and live inputs.
    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_TCSR: begin
                rd_val[2:0] = tick_ctrl;
                rd_val[16]  = tick_flag;
            end
            SEL_TCAL:  rd_val = CALIB_VAL;
            SEL_ICSR: begin
                rd_val[VEC_W-1:0]           = act_exc;
                rd_val[PEND_LSB +: VEC_W]   = pend_vec;
                rd_val[22]                  = ext_pend_any;
                rd_val[26]                  = exc_pend[EX_TICK];
                rd_val[28]                  = exc_pend[EX_PENDSV];
                rd_val[31]                  = exc_pend[EX_NMI];
            end
            SEL_VTOR:  rd_val = vtor;
            SEL_AIRCR: begin
                rd_val[31:16] = RESET_KEY;
                rd_val[10:8]  = prigroup;
            end
            SEL_SHP0:  rd_val = sys_prio[31:0];
            SEL_SHP1:  rd_val = sys_prio[63:32];
            SEL_SHP2:  rd_val = sys_prio[95:64];
            SEL_SHCSR: begin
                rd_val[0]     = exc_act[EX_MEM];
                rd_val[1]     = exc_act[EX_BUS];
                rd_val[3]     = exc_act[EX_USAGE];
                rd_val[7]     = exc_act[EX_SVC];
                rd_val[8]     = exc_act[EX_DBG];
                rd_val[10]    = exc_act[EX_PENDSV];
                rd_val[11]    = exc_act[EX_TICK];
                rd_val[12]    = exc_pend[EX_USAGE];
                rd_val[13]    = exc_pend[EX_MEM];
                rd_val[14]    = exc_pend[EX_BUS];
                rd_val[15]    = exc_pend[EX_SVC];
                rd_val[18:16] = hnd_en;
            end
            default:   rd_val = '0;
        endcase
    end

    // Register the read data on each read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    // Exception flags that no register exposes.
    assign unused_ok = ^{exc_pend[1:0], exc_pend[3], exc_pend[10:7],
                         exc_pend[13:12], exc_act[3:0], exc_act[10:7],
                         exc_act[13]};

endmodule

// File: rtl/sysctl_regs_chk.sv
// Module: sysctl_regs_chk
// Assertion checker bound into sysctl_regs. It observes the bus, the decoded
// select, the request pulses and the count flag.
module sysctl_regs_chk
    import sysctl_pkg::*;
#(
    parameter logic [31:0] CALIB_VAL = 32'd10000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input sel_e        sel,
    input logic        tick_wrap,
    input logic        tick_flag,
    input logic        pendsv_set,
    input logic        pendsv_clr,
    input logic        systick_set,
    input logic        systick_clr,
    input logic        prio_recalc,
    input logic [2:0]  prigroup,
    input logic [31:0] vtor
);

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[24:11], bus_wdata[6:0]};

    // R3: the set bit wins over the clear bit.
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_ICSR && bus_wdata[28]) |=> (pendsv_set && !pendsv_clr));

    // R3: the clear bit acts alone only when the set bit is absent.
    a_r3_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_ICSR && !bus_wdata[28] && bus_wdata[27]) |=> (pendsv_clr && !pendsv_set));

    // R4: the same rule for the tick exception.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_ICSR && bus_wdata[26]) |=> (systick_set && !systick_clr));

    // R5: the vector base loads with its low bits cleared.
    a_r5_vtor_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_VTOR) |=> (vtor == {$past(bus_wdata[31:7]), 7'b0}));

    // R6: a recompute pulse follows only a grouping write.
    a_r6_recalc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        prio_recalc |-> $past(bus_wr && sel == SEL_AIRCR));

    // R6: the grouping field takes data bits 10:8.
    a_r6_group_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_AIRCR) |=> (prigroup == $past(bus_wdata[10:8])));

    // R9: a wrap always leaves the flag set, even alongside a read.
    a_r9_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tick_wrap |=> tick_flag);

    // R9: a read with no wrap clears the flag.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_TCSR && !tick_wrap) |=> !tick_flag);

    // R10: the calibration read returns the constant.
    a_r10_calib: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_TCAL) |=> (bus_rdata == CALIB_VAL));

    // R11: undecoded reads return zero.
    a_r11_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == 32'd0));

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .CALIB_VAL (CALIB_VAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sel         (sel),
    .tick_wrap   (tick_wrap),
    .tick_flag   (tick_flag),
    .pendsv_set  (pendsv_set),
    .pendsv_clr  (pendsv_clr),
    .systick_set (systick_set),
    .systick_clr (systick_clr),
    .prio_recalc (prio_recalc),
    .prigroup    (prigroup),
    .vtor        (vtor)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural model predicts every output on each clock, and the
// outputs are compared at the falling edge.
module sysctl_regs_tb;

    localparam int VW = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [VW-1:0] act_exc = '0, pend_vec = '0;
    logic        ext_pend_any = 1'b0;
    logic [15:0] exc_pend = '0, exc_act = '0;
    logic        tick_wrap = 1'b0;
    logic        pendsv_set, pendsv_clr, systick_set, systick_clr, prio_recalc;
    logic [2:0]  hnd_en, prigroup, tick_ctrl;
    logic [31:0] vtor;
    logic [95:0] sys_prio;

    always #10 clk = ~clk;

    sysctl_regs u_dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_be (bus_be),
        .bus_rdata (bus_rdata), .act_exc (act_exc), .pend_vec (pend_vec),
        .ext_pend_any (ext_pend_any), .exc_pend (exc_pend), .exc_act (exc_act),
        .tick_wrap (tick_wrap), .pendsv_set (pendsv_set), .pendsv_clr (pendsv_clr),
        .systick_set (systick_set), .systick_clr (systick_clr), .hnd_en (hnd_en),
        .prigroup (prigroup), .prio_recalc (prio_recalc), .vtor (vtor),
        .sys_prio (sys_prio), .tick_ctrl (tick_ctrl)
    );

    // Reference model state
    logic [31:0] m_rdata = '0, m_vtor = '0;
    logic [2:0]  m_grp = '0, m_en = '0, m_tctl = '0;
    logic        m_flag = 1'b0, m_recalc = 1'b0;
    logic        m_ps = 1'b0, m_pc = 1'b0, m_ts = 1'b0, m_tc = 1'b0;
    logic [7:0]  m_prio [12];
    string       m_tag = "R1";
    bit          started = 0;
    int          nchk = 0, nbad = 0;

    initial for (int i = 0; i < 12; i++) m_prio[i] = '0;

    function automatic logic [31:0] mread(input logic [9:0] a);
        logic [31:0] v = '0;
        case (a)
            10'h004: begin v[2:0] = m_tctl; v[16] = m_flag; end
            10'h007: v = 32'd10000;
            10'h341: begin
                v[8:0] = act_exc; v[20:12] = pend_vec; v[22] = ext_pend_any;
                v[26] = exc_pend[15]; v[28] = exc_pend[14]; v[31] = exc_pend[2];
            end
            10'h342: v = m_vtor;
            10'h343: v = {16'hFA05, 5'd0, m_grp, 8'd0};
            10'h346, 10'h347, 10'h348:
                for (int b = 0; b < 4; b++) v[b*8 +: 8] = m_prio[(a - 10'h346) * 4 + b];
            10'h349: begin
                v[0] = exc_act[4]; v[1] = exc_act[5]; v[3] = exc_act[6];
                v[7] = exc_act[11]; v[8] = exc_act[12]; v[10] = exc_act[14];
                v[11] = exc_act[15]; v[12] = exc_pend[6]; v[13] = exc_pend[4];
                v[14] = exc_pend[5]; v[15] = exc_pend[11]; v[18:16] = m_en;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string tagof(input logic [9:0] a);
        case (a)
            10'h004: return "R9";
            10'h007: return "R10";
            10'h341: return "R2";
            10'h342: return "R5";
            10'h343: return "R6";
            10'h346, 10'h347, 10'h348: return "R8";
            10'h349: return "R7";
            default: return "R11";
        endcase
    endfunction

    // Model step at each rising edge.
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_rdata = '0; m_vtor = '0; m_grp = '0; m_en = '0; m_tctl = '0;
            m_flag = 0; m_recalc = 0; m_ps = 0; m_pc = 0; m_ts = 0; m_tc = 0;
            for (int i = 0; i < 12; i++) m_prio[i] = '0;
            m_tag = "R1";
        end else begin
            logic w_icsr;
            w_icsr = bus_wr && bus_addr == 10'h341;
            m_ps = w_icsr && bus_wdata[28];
            m_pc = w_icsr && !bus_wdata[28] && bus_wdata[27];
            m_ts = w_icsr && bus_wdata[26];
            m_tc = w_icsr && !bus_wdata[26] && bus_wdata[25];
            m_recalc = bus_wr && bus_addr == 10'h343;
            if (bus_rd) begin
                m_rdata = mread(bus_addr);
                m_tag = tagof(bus_addr);
            end
            if (tick_wrap) m_flag = 1;
            else if (bus_rd && bus_addr == 10'h004) m_flag = 0;
            if (bus_wr) begin
                case (bus_addr)
                    10'h004: m_tctl = bus_wdata[2:0];
                    10'h342: m_vtor = bus_wdata & 32'hFFFF_FF80;
                    10'h343: m_grp = bus_wdata[10:8];
                    10'h349: m_en = bus_wdata[18:16];
                    10'h346, 10'h347, 10'h348:
                        for (int b = 0; b < 4; b++)
                            if (bus_be[b]) m_prio[(bus_addr - 10'h346) * 4 + b] = bus_wdata[b*8 +: 8];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk(m_tag, bus_rdata, m_rdata);
            chk("R3 pendsv_set", 32'(pendsv_set), 32'(m_ps));
            chk("R3 pendsv_clr", 32'(pendsv_clr), 32'(m_pc));
            chk("R4 systick_set", 32'(systick_set), 32'(m_ts));
            chk("R4 systick_clr", 32'(systick_clr), 32'(m_tc));
            chk("R5 vtor", vtor, m_vtor);
            chk("R6 prigroup", 32'(prigroup), 32'(m_grp));
            chk("R6 prio_recalc", 32'(prio_recalc), 32'(m_recalc));
            chk("R7 hnd_en", 32'(hnd_en), 32'(m_en));
            chk("R9 tick_ctrl", 32'(tick_ctrl), 32'(m_tctl));
            for (int i = 0; i < 12; i++)
                chk("R8 sys_prio", 32'(sys_prio[i*8 +: 8]), 32'(m_prio[i]));
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [9:0] a,
                       input logic [31:0] d, input logic [3:0] be, input logic wr_tick);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; bus_be = be;
        tick_wrap = wr_tick;
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 4'hF, 0);
    endtask

    task automatic rd(input logic [9:0] a);
        cyc(0, 1, a, 32'h0, 4'h0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 10'h0, 32'h0, 4'h0, 0);
    endtask

    task automatic read_all();
        rd(10'h004); rd(10'h007); rd(10'h341); rd(10'h342); rd(10'h343);
        rd(10'h346); rd(10'h347); rd(10'h348); rd(10'h349);
    endtask

    // Watchdog
    initial begin
        #(20 * 100000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    logic [9:0] alist [12] = '{10'h004, 10'h007, 10'h341, 10'h342, 10'h343, 10'h346,
                               10'h347, 10'h348, 10'h349, 10'h000, 10'h340, 10'h3FF};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values on every register
        read_all();
        // R2: control/state composition under two input patterns
        act_exc = 9'h1A5; pend_vec = 9'h0F3; ext_pend_any = 1; exc_pend = 16'hC004;
        rd(10'h341);
        act_exc = 9'h003; pend_vec = 9'h1FF; ext_pend_any = 0; exc_pend = 16'h4000;
        rd(10'h341);
        // R3 / R4: all set/clear combinations
        wr(10'h341, 32'h1000_0000); wr(10'h341, 32'h0800_0000); wr(10'h341, 32'h1800_0000);
        wr(10'h341, 32'h0400_0000); wr(10'h341, 32'h0200_0000); wr(10'h341, 32'h0600_0000);
        wr(10'h341, 32'h1E00_0000); wr(10'h341, 32'h0A00_0000); wr(10'h341, 32'h0); idle();
        // R5: alignment on store
        wr(10'h342, 32'hFFFF_FFFF); rd(10'h342); wr(10'h342, 32'h1234_56FF); rd(10'h342);
        // R6: grouping write, pulse and readback
        wr(10'h343, 32'h05FA_0500); rd(10'h343); wr(10'h343, 32'hFFFF_F3FF); rd(10'h343); idle();
        // R7: enables and status bits
        exc_act = 16'hDFF0; exc_pend = 16'h0870;
        wr(10'h349, 32'hFFFF_FFFF); rd(10'h349); wr(10'h349, 32'h0002_0000); rd(10'h349);
        // R8: priority bytes with partial lanes
        cyc(1, 0, 10'h346, 32'h4433_2211, 4'b0101, 0);
        cyc(1, 0, 10'h347, 32'h8877_6655, 4'b1111, 0);
        cyc(1, 0, 10'h348, 32'hCCBB_AA99, 4'b1000, 0);
        cyc(1, 0, 10'h346, 32'hF0E0_D0C0, 4'b0010, 0);
        rd(10'h346); rd(10'h347); rd(10'h348);
        // R9: control bits, wrap, read clears, wrap and read together
        wr(10'h004, 32'hFFFF_FFFF); idle(); cyc(0, 0, 10'h0, 0, 0, 1);
        rd(10'h004); rd(10'h004);
        cyc(0, 0, 10'h0, 0, 0, 1); cyc(0, 1, 10'h004, 0, 0, 1);
        rd(10'h004); rd(10'h004);
        // R10: calibration constant
        rd(10'h007);
        // R11: undecoded offsets read zero and writes change nothing
        wr(10'h000, 32'hFFFF_FFFF); wr(10'h340, 32'hFFFF_FFFF); wr(10'h3FF, 32'hFFFF_FFFF);
        wr(10'h345, 32'hFFFF_FFFF); rd(10'h000); rd(10'h340); rd(10'h3FF); rd(10'h345);
        read_all();
        // Random phase: every collision with live inputs
        for (int n = 0; n < 600; n++) begin
            act_exc = 9'($urandom); pend_vec = 9'($urandom);
            ext_pend_any = 1'($urandom); exc_pend = 16'($urandom); exc_act = 16'($urandom);
            cyc(1'($urandom), 1'($urandom), alist[$urandom % 12], $urandom,
                4'($urandom), ($urandom % 4) == 0);
        end
        idle(); idle();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule